// File: doc/BRIEF.md
# Delayed Write Completion Tracker

This block holds the record of one delayed write that a bridge has forwarded to the far side of the bridge. The first attempt of a write that is not already held is latched: its address, command, byte enables and data are stored. A single-cycle request is raised toward the far-side queue, and the initiator receives a retry. Any attempt made while the write is still outstanding also receives a retry. Such an attempt never creates a second queue entry.

After the far side reports the write as finished, the initiator claims the completion by repeating the same write. The block compares the address, the command and the byte enables exactly. It compares the data only on lanes whose enable is active. A claimed write completes one data phase, and it ends with a disconnect when the initiator wanted more.

While an unclaimed completion sits at the head of the completion queue, a down-counter loaded from a programmable value runs. When the counter expires, the completion is dropped and an error-report request may be raised.

Top module: `dwc_tracker`

## Requirements
- R1: With no entry held, a write attempt (`attemptValid` high) is answered in the same cycle with `rspRetry` and a one-cycle `reqPush`, and the attempt's fields are stored as the entry.
- R2: While the stored write is still outstanding at the far side, every attempt, matching or not, gets `rspRetry` and no `reqPush`.
- R3: Once the far side has reported success (`farDone` with `farErr` low), a matching attempt gets `rspAccept` and no `rspRetry`, and the entry is freed, so that the next attempt is treated as new (R1).
- R4: `rspStop` is high together with `rspAccept` exactly when the claiming attempt has `attemptMulti` high; it is never high without `rspAccept`.
- R5: Byte enables are active low. Bit i of `attemptBeN` governs data bits [8i+7:8i]. Data on a lane whose enable bit is 1 is ignored in the match, and a data difference on a lane whose enable bit is 0 causes a retry.
- R6: An attempt whose address, command or byte-enable vector differs from the stored entry gets `rspRetry` and no `reqPush`, and the stored entry stays claimable.
- R7: A finished entry's counter is loaded with `reloadVal` in the cycle `farDone` is seen and counts down only in cycles with `atHead` high. In the L-th such cycle, `discardEvt` pulses for one cycle and the entry is removed.
- R8: `errFlagReq` pulses in the same cycle as `discardEvt` when `errRptEn` is high and stays low otherwise.
- R9: A reload value of zero disables discarding: the finished entry stays claimable however long `atHead` is high.
- R10: `farDone` with `farErr` high drops the entry, so the next attempt is retried and pushed as a new request.
- R11: A matching claim in the cycle in which the counter would expire wins: `rspAccept` is given and `discardEvt` stays low.
- R12: After reset, no entry is held and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attemptValid | input | 1 | A decoded write attempt is present this cycle |
| attemptAddr | input | ADDR_W | Attempt address |
| attemptCmd | input | CMD_W | Attempt bus command |
| attemptBeN | input | DATA_W/8 | Attempt byte enables, active low |
| attemptData | input | DATA_W | Attempt write data |
| attemptMulti | input | 1 | Initiator wants more than one data phase |
| farDone | input | 1 | Far side finished the forwarded write |
| farErr | input | 1 | Status of that completion: error |
| atHead | input | 1 | The completion is at the head of the completion queue |
| reloadVal | input | TMR_W | Discard counter start value, 0 disables |
| errRptEn | input | 1 | Enables the error-report request |
| rspRetry | output | 1 | Answer the attempt with a target retry |
| rspAccept | output | 1 | Accept one data phase of the attempt |
| rspStop | output | 1 | Disconnect along with the accepted phase |
| reqPush | output | 1 | Place the stored write in the far-side queue |
| discardEvt | output | 1 | The unclaimed completion was dropped |
| errFlagReq | output | 1 | One-cycle error-report request |

## Verification
The bench builds the tracker with a 64-bit data path and a 4-bit discard counter. The eight byte lanes let the masked compare be exercised with differences placed both on disabled upper lanes and on an enabled low lane. The narrow counter allows small reload values such as 3 and 2, so an expiry, a claim on the very cycle of expiry, and a long head-of-queue dwell with a zero reload all fit in a short run.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_OUTSTANDING = 2'd1,
    ST_FINISHED = 2'd2
  } dwcState_e;

  typedef struct packed {
    logic capture;
    logic tmrLoad;
    logic tmrRun;
  } dwcStrobe_t;

endpackage

// File: rtl/dwc_dpath.sv
module dwc_dpath
  import dwc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4,
  parameter int TMR_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dwcStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     attemptAddr,
  input  logic [CMD_W-1:0]      attemptCmd,
  input  logic [DATA_W/8-1:0]   attemptBeN,
  input  logic [DATA_W-1:0]     attemptData,
  input  logic [TMR_W-1:0]      reloadVal,
  input  logic                  atHead,
  output logic                  match,
  output logic                  tmrExpire
);

  localparam int BE_W = DATA_W / 8;

  logic [ADDR_W-1:0] recAddr;
  logic [CMD_W-1:0]  recCmd;
  logic [BE_W-1:0]   recBeN;
  logic [DATA_W-1:0] recData;
  logic [TMR_W-1:0]  tmrCnt;
  logic [BE_W-1:0]   laneOk;

  // Entry record
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recAddr <= '0;
      recCmd  <= '0;
      recBeN  <= '1;
      recData <= '0;
    end else if (strobe.capture) begin
      recAddr <= attemptAddr;
      recCmd  <= attemptCmd;
      recBeN  <= attemptBeN;
      recData <= attemptData;
    end
  end

  // Per-lane compare, masked by the stored active-low enables
  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    assign laneOk[lane] = recBeN[lane] |
        (recData[lane*8 +: 8] == attemptData[lane*8 +: 8]);
  end

  assign match = (attemptAddr == recAddr) && (attemptCmd == recCmd) &&
                 (attemptBeN == recBeN) && (&laneOk);

  // Head-of-queue discard counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmrCnt <= '0;
    end else if (strobe.tmrLoad) begin
      tmrCnt <= reloadVal;
    end else if (!strobe.tmrRun) begin
      tmrCnt <= '0;
    end else if (atHead && (tmrCnt != '0)) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign tmrExpire = strobe.tmrRun && atHead && (tmrCnt == TMR_W'(1));

endmodule

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
  import dwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       attemptValid,
  input  logic       attemptMulti,
  input  logic       farDone,
  input  logic       farErr,
  input  logic       errRptEn,
  input  logic       match,
  input  logic       tmrExpire,
  output dwcStrobe_t strobe,
  output logic       rspRetry,
  output logic       rspAccept,
  output logic       rspStop,
  output logic       reqPush,
  output logic       discardEvt,
  output logic       errFlagReq
);

  dwcState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_EMPTY;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    rspRetry   = 1'b0;
    rspAccept  = 1'b0;
    rspStop    = 1'b0;
    reqPush    = 1'b0;
    discardEvt = 1'b0;
    errFlagReq = 1'b0;
    unique case (state)
      ST_EMPTY: begin
        if (attemptValid) begin
          rspRetry       = 1'b1;
          reqPush        = 1'b1;
          strobe.capture = 1'b1;
          stateNext      = ST_OUTSTANDING;
        end
      end
      ST_OUTSTANDING: begin
        rspRetry = attemptValid;
        if (farDone) begin
          if (farErr) begin
            stateNext = ST_EMPTY;
          end else begin
            strobe.tmrLoad = 1'b1;
            stateNext      = ST_FINISHED;
          end
        end
      end
      ST_FINISHED: begin
        strobe.tmrRun = 1'b1;
        if (attemptValid && match) begin
          rspAccept = 1'b1;
          rspStop   = attemptMulti;
          stateNext = ST_EMPTY;
        end else begin
          rspRetry = attemptValid;
          if (tmrExpire) begin
            discardEvt = 1'b1;
            errFlagReq = errRptEn;
            stateNext  = ST_EMPTY;
          end
        end
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

endmodule

// File: rtl/dwc_tracker.sv
module dwc_tracker
  import dwc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4,
  parameter int TMR_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                attemptValid,
  input  logic [ADDR_W-1:0]   attemptAddr,
  input  logic [CMD_W-1:0]    attemptCmd,
  input  logic [DATA_W/8-1:0] attemptBeN,
  input  logic [DATA_W-1:0]   attemptData,
  input  logic                attemptMulti,
  input  logic                farDone,
  input  logic                farErr,
  input  logic                atHead,
  input  logic [TMR_W-1:0]    reloadVal,
  input  logic                errRptEn,
  output logic                rspRetry,
  output logic                rspAccept,
  output logic                rspStop,
  output logic                reqPush,
  output logic                discardEvt,
  output logic                errFlagReq
);

  dwcStrobe_t strobe;
  logic       match;
  logic       tmrExpire;

  dwc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .attemptValid(attemptValid), .attemptMulti(attemptMulti),
    .farDone(farDone), .farErr(farErr), .errRptEn(errRptEn),
    .match(match), .tmrExpire(tmrExpire), .strobe(strobe),
    .rspRetry(rspRetry), .rspAccept(rspAccept), .rspStop(rspStop),
    .reqPush(reqPush), .discardEvt(discardEvt), .errFlagReq(errFlagReq)
  );

  dwc_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .TMR_W(TMR_W)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .attemptAddr(attemptAddr), .attemptCmd(attemptCmd),
    .attemptBeN(attemptBeN), .attemptData(attemptData),
    .reloadVal(reloadVal), .atHead(atHead),
    .match(match), .tmrExpire(tmrExpire)
  );

endmodule

// File: rtl/dwc_checker.sv
module dwc_checker (
  input logic clk,
  input logic rst_n,
  input logic attemptValid,
  input logic errRptEn,
  input logic rspRetry,
  input logic rspAccept,
  input logic rspStop,
  input logic reqPush,
  input logic discardEvt,
  input logic errFlagReq
);

  assert_resp_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rspRetry && rspAccept));

  assert_stop_with_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rspStop |-> rspAccept);

  assert_push_is_retry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqPush |-> (rspRetry && attemptValid));

  assert_single_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqPush |=> !reqPush);

  assert_quiet_without_attempt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !attemptValid |-> (!rspRetry && !rspAccept && !reqPush));

  assert_discard_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    discardEvt |=> !discardEvt);

  assert_err_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    errFlagReq |-> (discardEvt && errRptEn));

  assert_claim_beats_discard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rspAccept |-> !discardEvt);

endmodule

bind dwc_tracker dwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .attemptValid(attemptValid), .errRptEn(errRptEn),
  .rspRetry(rspRetry), .rspAccept(rspAccept), .rspStop(rspStop),
  .reqPush(reqPush), .discardEvt(discardEvt), .errFlagReq(errFlagReq)
);

// File: tb/sim_dwc_tracker.sv
`timescale 1ns/1ps
module sim_dwc_tracker;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int CMD_W  = 4;
  localparam int TMR_W  = 4;
  localparam int BE_W   = DATA_W / 8;

  // expected vector bits: {retry, accept, stop, push, discard, err}
  localparam logic [5:0] E_NONE  = 6'b000000;
  localparam logic [5:0] E_RTRY  = 6'b100000;
  localparam logic [5:0] E_NEW   = 6'b100100;
  localparam logic [5:0] E_ACC   = 6'b010000;
  localparam logic [5:0] E_ACCST = 6'b011000;
  localparam logic [5:0] E_DISC  = 6'b000010;
  localparam logic [5:0] E_DISCE = 6'b000011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic attemptValid = 1'b0;
  logic [ADDR_W-1:0] attemptAddr = '0;
  logic [CMD_W-1:0]  attemptCmd = '0;
  logic [BE_W-1:0]   attemptBeN = '1;
  logic [DATA_W-1:0] attemptData = '0;
  logic attemptMulti = 1'b0;
  logic farDone = 1'b0;
  logic farErr = 1'b0;
  logic atHead = 1'b0;
  logic [TMR_W-1:0] reloadVal = '0;
  logic errRptEn = 1'b0;
  logic rspRetry, rspAccept, rspStop, reqPush, discardEvt, errFlagReq;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dwc_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .TMR_W(TMR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .attemptValid(attemptValid), .attemptAddr(attemptAddr),
    .attemptCmd(attemptCmd), .attemptBeN(attemptBeN), .attemptData(attemptData),
    .attemptMulti(attemptMulti), .farDone(farDone), .farErr(farErr), .atHead(atHead),
    .reloadVal(reloadVal), .errRptEn(errRptEn), .rspRetry(rspRetry),
    .rspAccept(rspAccept), .rspStop(rspStop), .reqPush(reqPush),
    .discardEvt(discardEvt), .errFlagReq(errFlagReq)
  );

  function automatic logic [5:0] outVec();
    return {rspRetry, rspAccept, rspStop, reqPush, discardEvt, errFlagReq};
  endfunction

  // driver: inputs are already set at a falling edge; record expectation, advance
  task automatic cyc(input logic [5:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    attemptValid = 1'b0;
    farDone = 1'b0;
    farErr = 1'b0;
  endtask

  task automatic setAttempt(input logic [ADDR_W-1:0] a, input logic [CMD_W-1:0] c,
                            input logic [BE_W-1:0] b, input logic [DATA_W-1:0] d,
                            input logic m);
    attemptValid = 1'b1;
    attemptAddr = a;
    attemptCmd = c;
    attemptBeN = b;
    attemptData = d;
    attemptMulti = m;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops one expectation per cycle, samples mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (outVec() !== it.exp) begin
          fails++;
          $display("FAIL %s: got %b expected %b", it.tag, outVec(), it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  localparam logic [63:0] D1 = 64'h0123_4567_89AB_CDEF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    checks++;
    if (outVec() !== E_NONE) begin
      fails++;
      $display("FAIL R12: got %b expected %b", outVec(), E_NONE);
    end
    @(negedge clk);
    reloadVal = 4'd3;
    errRptEn = 1'b1;

    // R1 first attempt, R2 repeats while outstanding
    setAttempt(32'h100, 4'h7, 8'h00, D1, 1'b0); cyc(E_NEW, "R1");
    setAttempt(32'h100, 4'h7, 8'h00, D1, 1'b0); cyc(E_RTRY, "R2");
    setAttempt(32'h104, 4'h7, 8'h00, D1, 1'b0); cyc(E_RTRY, "R2");
    atHead = 1'b0;
    farDone = 1'b1; cyc(E_NONE, "R3");
    // R6 field mismatches keep entry
    setAttempt(32'h108, 4'h7, 8'h00, D1, 1'b0); cyc(E_RTRY, "R6");
    setAttempt(32'h100, 4'h6, 8'h00, D1, 1'b0); cyc(E_RTRY, "R6");
    setAttempt(32'h100, 4'h7, 8'h01, D1, 1'b0); cyc(E_RTRY, "R6");
    // R3/R4 claim with disconnect
    setAttempt(32'h100, 4'h7, 8'h00, D1, 1'b1); cyc(E_ACCST, "R4");
    // entry freed: same write is new again
    setAttempt(32'h100, 4'h7, 8'hF0, D1, 1'b0); cyc(E_NEW, "R3");
    farDone = 1'b1; cyc(E_NONE, "R3");
    // R5 disabled upper lanes differ -> still a match
    setAttempt(32'h100, 4'h7, 8'hF0, D1 ^ 64'hFFFF_FFFF_0000_0000, 1'b0); cyc(E_ACC, "R5");
    // R5 enabled lane differs -> retry
    setAttempt(32'h200, 4'h7, 8'hF0, D1, 1'b0); cyc(E_NEW, "R5");
    farDone = 1'b1; cyc(E_NONE, "R5");
    setAttempt(32'h200, 4'h7, 8'hF0, D1 ^ 64'h1, 1'b0); cyc(E_RTRY, "R5");
    // R7 counter idle without head
    for (int i = 0; i < 5; i++) cyc(E_NONE, "R7");
    atHead = 1'b1;
    cyc(E_NONE, "R7");
    cyc(E_NONE, "R7");
    cyc(E_DISCE, "R8");
    atHead = 1'b0;
    cyc(E_NONE, "R7");
    setAttempt(32'h200, 4'h7, 8'hF0, D1, 1'b0); cyc(E_NEW, "R7");
    // R8 with report disabled
    errRptEn = 1'b0;
    farDone = 1'b1; cyc(E_NONE, "R8");
    atHead = 1'b1;
    cyc(E_NONE, "R8");
    cyc(E_NONE, "R8");
    cyc(E_DISC, "R8");
    atHead = 1'b0;
    // R9 zero reload never discards
    reloadVal = 4'd0;
    setAttempt(32'h300, 4'h3, 8'h0F, D1, 1'b0); cyc(E_NEW, "R9");
    farDone = 1'b1; cyc(E_NONE, "R9");
    atHead = 1'b1;
    for (int i = 0; i < 20; i++) cyc(E_NONE, "R9");
    setAttempt(32'h300, 4'h3, 8'h0F, D1, 1'b0); cyc(E_ACC, "R9");
    atHead = 1'b0;
    // R10 far error drops entry
    reloadVal = 4'd2;
    errRptEn = 1'b1;
    setAttempt(32'h400, 4'h7, 8'h00, D1, 1'b0); cyc(E_NEW, "R10");
    farDone = 1'b1; farErr = 1'b1; cyc(E_NONE, "R10");
    setAttempt(32'h400, 4'h7, 8'h00, D1, 1'b0); cyc(E_NEW, "R10");
    // R11 claim on the expiry cycle
    farDone = 1'b1; cyc(E_NONE, "R11");
    atHead = 1'b1;
    cyc(E_NONE, "R11");
    setAttempt(32'h400, 4'h7, 8'h00, D1, 1'b0); cyc(E_ACC, "R11");
    cyc(E_NONE, "R11");
    atHead = 1'b0;
    cyc(E_NONE, "R11");
    repeat (2) @(negedge clk);
    summary();
  end

endmodule